// File: doc/BRIEF.md
# Elastic Bit Store with Frame-Rate Stuff Comparator

This block buffers a serial bit stream arriving at the receive rate and hands it out again at the rate set by the multiplexer's output timing. Incoming bits go into a sixteen-cell store, organised as two banks of eight one-bit cells. A write pointer fills the store. A read pointer empties it, one bit per enabled output tick. After reset the write pointer sits eight cells ahead of the read pointer, so the store starts half full.

Once per frame the block measures how far apart the two pointers have drifted. A frame marker captures the read pointer. The write pointer is captured at the next received bit. The two captures are combined into a four-bit difference code. That code is decoded into one of three outcomes: positive stuff, negative stuff, or out-of-tolerance. The code and the outcome are held until the next frame's measurement. A positive-stuff command is released only while the frame's stuff window is open. A negative-stuff command is driven active low.

A mode input selects how the read side is paced. In one mode every output tick reads a bit. In the other mode a tick reads only while an external coarse-rate enable is high.

Top module: `elastic_stuff_top`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets the write pointer to 8 and the read pointer to 0, and clears every store cell. After reset, `diffCode` is 0, all three flags are low, `posCmd` is low and `negCmdN` is high.
- R2: On every clock edge where `wrEn` is high, `wrData` is written to the cell at the write pointer and the write pointer advances by one modulo 16. Pointer bit 3 selects the bank and bits 2..0 select the cell within that bank.
- R3: On every edge with an open read gate and `rdTick` high, `rdData` is loaded from the cell at the read pointer, and the read pointer advances by one modulo 16. As long as the write lead stays between 1 and 15, `rdData` after reset therefore carries eight 0 bits followed by the written bits in their original order.
- R4: With `coarseMode` = 0 the read gate is always open. With `coarseMode` = 1 the gate follows `coarseEn`. A tick that arrives while the gate is closed leaves `rdData` and the read pointer unchanged.
- R5: When `frameMark` is high at an edge, the read pointer value from before that edge is captured. At the next edge where `wrEn` is high, the write pointer value from before that edge is captured.
- R6: At the write-capture edge, `diffCode` becomes (read capture + bitwise NOT of write capture) mod 16. If both clocks keep pace with a write lead of L at the marker edge, and `wrEn` is high at the marker edge, the code is (14 − L) mod 16, which is 0110 at L = 8.
- R7: The flags are decoded from the code. Code 0110 raises no flag. Codes 0111 to 1001 raise `posFlag`. Codes 0011 to 0101 raise `negFlag`. Every other code raises `tolFlag`. At most one flag is ever high.
- R8: `diffCode` and the flags change only at a write-capture edge and hold their values in between.
- R9: `posCmd` is high exactly when `posFlag` and `stuffWindow` are both high. `negCmdN` is the inverse of `negFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Received bit strobe |
| wrData | input | 1 | Received bit |
| rdTick | input | 1 | Output bit tick |
| coarseMode | input | 1 | 1: read gate follows coarseEn; 0: read gate always open |
| coarseEn | input | 1 | External coarse-rate read enable |
| frameMark | input | 1 | Frame measurement point; read pointer is captured here |
| stuffWindow | input | 1 | Frame window that permits the positive command |
| rdData | output | 1 | Registered output bit |
| diffCode | output | 4 | Held pointer difference code |
| posFlag | output | 1 | Positive stuff needed |
| negFlag | output | 1 | Negative stuff needed |
| tolFlag | output | 1 | Pointers out of tolerance |
| posCmd | output | 1 | Positive stuff command, gated by the window |
| negCmdN | output | 1 | Negative stuff command, active low |

## Verification
The hold and decode properties assume two things about the inputs: `frameMark` arrives together with a received bit, and at most one measurement is in progress at a time. The stimulus therefore always raises the marker in a cycle with `wrEn` high, follows it with a second write cycle, and leaves many cycles between markers. The read-order scoreboard is valid only while the write lead stays between 1 and 15. To keep within that range, the stimulus shifts the lead one step at a time, between 4 and 12, using write-only or read-only cycles, and the bench tracks the lead itself.

// File: rtl/elastic_pkg.sv
package elastic_pkg;
  localparam int ADDR_W     = 4;
  localparam int NUM_BANKS  = 2;
  localparam int BANK_W     = ADDR_W - 1;
  localparam int BANK_CELLS = 1 << BANK_W;
  localparam logic [ADDR_W-1:0] WR_START = ADDR_W'(1 << (ADDR_W - 1));
  localparam logic [ADDR_W-1:0] RD_START = '0;
  localparam logic [ADDR_W-1:0] NOMINAL  = ADDR_W'(6);
  localparam int STUFF_SPAN = 3;

  typedef struct packed {
    logic capRd;
    logic capWr;
    logic wrStep;
    logic rdStep;
  } esStrobe_t;
endpackage

// File: rtl/es_control.sv
module es_control
  import elastic_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wrEn,
  input  logic      rdTick,
  input  logic      coarseMode,
  input  logic      coarseEn,
  input  logic      frameMark,
  output esStrobe_t strobes
);
  logic armed;
  logic readGate;

  assign readGate = coarseMode ? coarseEn : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (frameMark) begin
      armed <= 1'b1;
    end else if (armed && wrEn) begin
      armed <= 1'b0;
    end
  end

  always_comb begin
    strobes.capRd  = frameMark && !rst;
    strobes.capWr  = armed && wrEn && !frameMark && !rst;
    strobes.wrStep = wrEn && !rst;
    strobes.rdStep = rdTick && readGate && !rst;
  end
endmodule

// File: rtl/es_datapath.sv
module es_datapath
  import elastic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  esStrobe_t         strobes,
  input  logic              wrData,
  output logic              rdData,
  output logic [ADDR_W-1:0] diffCode,
  output logic              posFlag,
  output logic              negFlag,
  output logic              tolFlag
);
  logic [NUM_BANKS-1:0][BANK_CELLS-1:0] mem;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] rdCap;
  logic [NUM_BANKS-1:0] bankBit;
  logic rdBit;
  logic [ADDR_W-1:0] nextCode;
  logic [ADDR_W-1:0] delta;
  logic nextPos, nextNeg, nextTol;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem    <= '0;
      wrAddr <= WR_START;
    end else if (strobes.wrStep) begin
      mem[wrAddr[ADDR_W-1]][wrAddr[BANK_W-1:0]] <= wrData;
      wrAddr <= wrAddr + 1'b1;
    end
  end

  // AND-OR bank select: each bank contributes only when the top bit names it
  for (genvar b = 0; b < NUM_BANKS; b++) begin : genBankSel
    assign bankBit[b] = mem[b][rdAddr[BANK_W-1:0]] && (rdAddr[ADDR_W-1] == 1'(b));
  end
  assign rdBit = |bankBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdAddr <= RD_START;
      rdData <= 1'b0;
    end else if (strobes.rdStep) begin
      rdData <= rdBit;
      rdAddr <= rdAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdCap <= '0;
    else if (strobes.capRd) rdCap <= rdAddr;
  end

  always_comb begin
    nextCode = rdCap + ~wrAddr;
    delta    = nextCode - NOMINAL;
    nextPos  = (delta >= ADDR_W'(1)) && (delta <= ADDR_W'(STUFF_SPAN));
    nextNeg  = (delta >= ADDR_W'((1 << ADDR_W) - STUFF_SPAN));
    nextTol  = (delta != '0) && !nextPos && !nextNeg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      diffCode <= '0;
      posFlag  <= 1'b0;
      negFlag  <= 1'b0;
      tolFlag  <= 1'b0;
    end else if (strobes.capWr) begin
      diffCode <= nextCode;
      posFlag  <= nextPos;
      negFlag  <= nextNeg;
      tolFlag  <= nextTol;
    end
  end
endmodule

// File: rtl/elastic_stuff_top.sv
module elastic_stuff_top
  import elastic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrData,
  input  logic              rdTick,
  input  logic              coarseMode,
  input  logic              coarseEn,
  input  logic              frameMark,
  input  logic              stuffWindow,
  output logic              rdData,
  output logic [ADDR_W-1:0] diffCode,
  output logic              posFlag,
  output logic              negFlag,
  output logic              tolFlag,
  output logic              posCmd,
  output logic              negCmdN
);
  esStrobe_t strobes;

  es_control ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdTick(rdTick),
    .coarseMode(coarseMode), .coarseEn(coarseEn),
    .frameMark(frameMark), .strobes(strobes)
  );

  es_datapath dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .rdData(rdData), .diffCode(diffCode),
    .posFlag(posFlag), .negFlag(negFlag), .tolFlag(tolFlag)
  );

  assign posCmd  = posFlag && stuffWindow;
  assign negCmdN = !negFlag;
endmodule

// File: rtl/es_checker.sv
module es_checker
  import elastic_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              coarseMode,
  input logic              coarseEn,
  input logic              stuffWindow,
  input logic              capWr,
  input logic              rdData,
  input logic [ADDR_W-1:0] diffCode,
  input logic              posFlag,
  input logic              negFlag,
  input logic              tolFlag,
  input logic              posCmd
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!posFlag && !negFlag && !tolFlag && diffCode == '0));

  assert_gate_closed_R4: assert property (@(posedge clk) disable iff (rst)
    (coarseMode && !coarseEn) |=> $stable(rdData));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({posFlag, negFlag, tolFlag}));

  assert_nominal_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (diffCode == NOMINAL) |-> !(posFlag || negFlag || tolFlag));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(capWr) |-> ($stable(diffCode) && $stable({posFlag, negFlag, tolFlag})));

  assert_pos_window_R9: assert property (@(posedge clk) disable iff (rst)
    posCmd |-> (stuffWindow && posFlag));
endmodule

bind elastic_stuff_top es_checker chk_i (
  .clk(clk), .rst(rst), .coarseMode(coarseMode), .coarseEn(coarseEn),
  .stuffWindow(stuffWindow), .capWr(strobes.capWr), .rdData(rdData),
  .diffCode(diffCode), .posFlag(posFlag), .negFlag(negFlag),
  .tolFlag(tolFlag), .posCmd(posCmd)
);

// File: tb/elastic_stuff_top_tb_top.sv
`timescale 1ns/1ps
module elastic_stuff_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 0, wrData = 0, rdTick = 0, coarseMode = 0, coarseEn = 0;
  logic frameMark = 0, stuffWindow = 0;
  logic rdData, posFlag, negFlag, tolFlag, posCmd, negCmdN;
  logic [3:0] diffCode;

  int checks = 0;
  int errors = 0;
  int lead = 8;
  bit done = 0;
  bit rdFired = 0;
  bit sbQ[$];

  always #2 clk = ~clk;

  elastic_stuff_top dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdTick(rdTick),
    .coarseMode(coarseMode), .coarseEn(coarseEn), .frameMark(frameMark),
    .stuffWindow(stuffWindow), .rdData(rdData), .diffCode(diffCode),
    .posFlag(posFlag), .negFlag(negFlag), .tolFlag(tolFlag),
    .posCmd(posCmd), .negCmdN(negCmdN)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: pushes written bits as expected items (R2, R3)
  always @(posedge clk) begin
    rdFired <= !rst && rdTick && (!coarseMode || coarseEn);
    if (!rst && wrEn) sbQ.push_back(wrData);
  end

  // Monitor: compares each output bit in order (R3)
  always @(negedge clk) begin
    if (rdFired) begin
      if (sbQ.size() == 0) check("R3 queue empty", 1, 0);
      else check("R3 read order", int'(rdData), int'(sbQ.pop_front()));
    end
  end

  task automatic step(bit w, bit r, bit f);
    wrEn = w; rdTick = r; frameMark = f;
    wrData = w ? 1'($urandom) : 1'b0;
    @(posedge clk);
    if (w) lead++;
    if (r && (!coarseMode || coarseEn)) lead--;
    @(negedge clk);
    wrEn = 0; rdTick = 0; frameMark = 0;
  endtask

  task automatic run(int n, bit w, bit r);
    for (int i = 0; i < n; i++) step(w, r, 1'b0);
  endtask

  // Expected outcome from the R7 thresholds: 0 none, 1 pos, 2 neg, 3 tol
  function automatic int expKind(int code);
    if (code == 6) return 0;
    if (code >= 7 && code <= 9) return 1;
    if (code >= 3 && code <= 5) return 2;
    return 3;
  endfunction

  task automatic frame(string req);
    int code;
    code = (14 - lead) & 15;
    step(1, 1, 1);
    step(1, 1, 0);
    check({req, " R5 R6 code"}, int'(diffCode), code);
    check({req, " R7 pos"}, int'(posFlag), int'(expKind(code) == 1));
    check({req, " R7 neg"}, int'(negFlag), int'(expKind(code) == 2));
    check({req, " R7 tol"}, int'(tolFlag), int'(expKind(code) == 3));
    check({req, " R9 negCmdN"}, int'(negCmdN), int'(expKind(code) != 2));
  endtask

  initial begin
    logic held;
    for (int i = 0; i < 8; i++) sbQ.push_back(1'b0);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 code", int'(diffCode), 0);
    check("R1 flags", int'({posFlag, negFlag, tolFlag}), 0);
    check("R1 negCmdN", int'(negCmdN), 1);
    check("R1 posCmd", int'(posCmd), 0);
    check("R1 rdData", int'(rdData), 0);
    run(20, 1, 1);
    frame("R1 nominal");                 // lead 8 -> 0110
    run(1, 0, 1);                        // lead 7
    frame("L7");
    check("R9 posCmd window closed", int'(posCmd), 0);
    stuffWindow = 1; #1;
    check("R9 posCmd window open", int'(posCmd), 1);
    stuffWindow = 0;
    run(2, 0, 1);                        // lead 5, code 1001 edge
    frame("L5");
    run(1, 0, 1);                        // lead 4, code 1010
    frame("L4");
    run(5, 1, 0);                        // lead 9
    frame("L9");
    run(2, 1, 0);                        // lead 11, code 0011 edge
    frame("L11");
    run(1, 1, 0);                        // lead 12, code 0010
    frame("L12");
    // R8 hold between captures while lead moves
    run(4, 0, 1);
    check("R8 code held", int'(diffCode), 2);
    check("R8 tol held", int'(tolFlag), 1);
    frame("back to nominal");
    // R4 gate closed: ticks ignored
    coarseMode = 1; coarseEn = 0;
    held = rdData;
    run(3, 1, 1);                        // lead 11
    check("R4 rdData stable", int'(rdData), int'(held));
    coarseEn = 1;
    run(6, 1, 1);
    frame("R4 gated L11");
    run(3, 0, 1);                        // lead 8
    frame("R4 gated nominal");
    coarseMode = 0;
    run(24, 1, 1);
    run(3, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule